// File: doc/BRIEF.md
# Dual-Write Register File

This block holds eight 32-bit program registers for a simple processor core. Each register is selected by a 4-bit register ID, and IDs 0 to 7 pick the eight registers. The block has two read ports, called X and Y. Both are combinational, so data appears in the same cycle as the address. It also has two write ports, called EX and MEM, which commit on the rising clock edge. All four ports can be used in the same cycle.

The ID 15 (4'hF) is reserved to mean "no register". Reading ID 15 returns zero, and writing ID 15 does nothing. Reading any unused ID from 8 to 14 also returns zero, and writing such an ID is ignored. When both write ports target the same register in one cycle, the MEM port's value is stored. A read in the same cycle as a write to the same register returns the value from before the write. Reset is synchronous and clears every register to zero.

Top module: `dual_wr_regfile`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), reading any of IDs 0 to 7 on either read port returns 32'h0.
- R2: A write on the EX port with an ID from 0 to 7 updates that register at the next rising edge. Both read ports then return the written value.
- R3: A write on the MEM port with an ID from 0 to 7 updates that register at the next rising edge.
- R4: EX and MEM writes to different registers in the same cycle both take effect.
- R5: When EX and MEM target the same register in the same cycle, the MEM data is stored.
- R6: A write to ID 15 (4'hF) on either write port changes no register.
- R7: A read with ID 15 or with any ID from 8 to 14 returns 32'h0 on either read port.
- R8: A read of a register that is being written in the same cycle returns the old value until the edge. There is no bypass.
- R9: The two read ports are independent: each returns the content of its own ID in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_x_id | input | 4 | Read port X register ID |
| rd_x_data | output | 32 | Read port X data (combinational) |
| rd_y_id | input | 4 | Read port Y register ID |
| rd_y_data | output | 32 | Read port Y data (combinational) |
| wr_ex_id | input | 4 | EX write port register ID (4'hF = none) |
| wr_ex_data | input | 32 | EX write port data |
| wr_mem_id | input | 4 | MEM write port register ID (4'hF = none) |
| wr_mem_data | input | 32 | MEM write port data |

## Verification
The bench drives several write patterns and checks the result on every cycle.

- **Single-port writes:** show that each write port reaches every register.
- **Distinct-target dual writes:** show that both ports can commit in the same cycle.
- **Same-target dual writes:** show the priority order, because a wrong priority stores the EX data.
- **Null and unused IDs:** drive writes and reads with IDs 8 to 15, which exposes any decode that aliases the upper IDs onto real registers.
- **Read during write:** read a register in the same cycle it is written, before the edge, to detect an unwanted bypass.
- **Random four-port traffic:** run many cycles compared against a behavioural array model.

// File: rtl/rf_pkg.sv
package rf_pkg;
    parameter int DATA_W  = 32;
    parameter int ID_W    = 4;
    parameter int NUM_REG = 8;
    localparam logic [ID_W-1:0] NULL_ID = '1;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ID_W-1:0]   rid_t;
    typedef struct packed {
        logic  en;
        rid_t  id;
        word_t data;
    } wr_req_t;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
    import rf_pkg::*;
#(
    parameter int NREG = NUM_REG
) (
    input  rid_t            id,
    output logic [NREG-1:0] sel
);
    always_comb begin
        sel = '0;
        for (int i = 0; i < NREG; i++) begin
            if (id == rid_t'(i)) sel[i] = 1'b1;
        end
    end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
    import rf_pkg::*;
#(
    parameter int NREG = NUM_REG
) (
    input  word_t regs [NREG],
    input  rid_t  id,
    output word_t data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (id == rid_t'(i)) data = regs[i];
        end
    end
endmodule

// File: rtl/dual_wr_regfile.sv
module dual_wr_regfile
    import rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  rd_x_id,
    output logic [31:0] rd_x_data,
    input  logic [3:0]  rd_y_id,
    output logic [31:0] rd_y_data,
    input  logic [3:0]  wr_ex_id,
    input  logic [31:0] wr_ex_data,
    input  logic [3:0]  wr_mem_id,
    input  logic [31:0] wr_mem_data
);
    typedef struct packed {
        word_t [NUM_REG-1:0] r;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic [NUM_REG-1:0] ex_sel, mem_sel;
    word_t regs_view [NUM_REG];

    rf_wr_decode u_dec_ex  (.id(wr_ex_id),  .sel(ex_sel));
    rf_wr_decode u_dec_mem (.id(wr_mem_id), .sel(mem_sel));

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            for (int i = 0; i < NUM_REG; i++) begin
                if (mem_sel[i])     st_d.r[i] = wr_mem_data;
                else if (ex_sel[i]) st_d.r[i] = wr_ex_data;
            end
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    for (genvar g = 0; g < NUM_REG; g++) begin : g_view
        assign regs_view[g] = st_q.r[g];
    end

    rf_rd_port u_rd_x (.regs(regs_view), .id(rd_x_id), .data(rd_x_data));
    rf_rd_port u_rd_y (.regs(regs_view), .id(rd_y_id), .data(rd_y_data));

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (st_q == '0));
    p_ex_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ex_id < 4'd8 && wr_ex_id != wr_mem_id)
            |=> (st_q.r[$past(wr_ex_id[2:0])] == $past(wr_ex_data)));
    p_mem_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_mem_id < 4'd8) |=> (st_q.r[$past(wr_mem_id[2:0])] == $past(wr_mem_data)));
    p_null_read_x_r7: assert property (@(posedge clk)
        (rd_x_id >= 4'd8) |-> (rd_x_data == '0));
    p_null_read_y_r7: assert property (@(posedge clk)
        (rd_y_id >= 4'd8) |-> (rd_y_data == '0));
    p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_ex_id >= 4'd8 && wr_mem_id >= 4'd8) |=> $stable(st_q));
endmodule

// File: tb/dual_wr_regfile_test.sv
module dual_wr_regfile_test;
    logic clk = 0;
    logic rst;
    logic [3:0]  rd_x_id, rd_y_id, wr_ex_id, wr_mem_id;
    logic [31:0] rd_x_data, rd_y_data, wr_ex_data, wr_mem_data;
    int checks = 0, fails = 0;
    logic [31:0] model [8];
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_wr_regfile uut (.*);

    function automatic logic [31:0] mread(input logic [3:0] id);
        return (id < 8) ? model[id[2:0]] : 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] ei, input logic [31:0] ed,
                         input logic [3:0] mi, input logic [31:0] md);
        wr_ex_id = ei; wr_ex_data = ed; wr_mem_id = mi; wr_mem_data = md;
    endtask

    task automatic step;
        @(posedge clk);
        if (rst) foreach (model[i]) model[i] = 0;
        else begin
            if (wr_ex_id < 8)  model[wr_ex_id[2:0]]  = wr_ex_data;
            if (wr_mem_id < 8) model[wr_mem_id[2:0]] = wr_mem_data;
        end
        @(negedge clk);
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [3:0] b);
        rd_x_id = a; rd_y_id = b; #0.5;
        chk(req, rd_x_data, mread(a));
        chk(req, rd_y_data, mread(b));
    endtask

    initial begin
        #150000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; drive(4'hF, 0, 4'hF, 0); rd_x_id = 0; rd_y_id = 0;
        foreach (model[i]) model[i] = 32'hX;
        @(negedge clk); step; rst = 0;
        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd_x_id = 4'(i); rd_y_id = 4'(i); #0.5;
            chk("R1", rd_x_data, 0); chk("R1", rd_y_data, 0);
        end
        // R2 EX writes
        for (int i = 0; i < 8; i++) begin
            drive(4'(i), 32'h1000_0000 + i, 4'hF, 0); step;
        end
        drive(4'hF, 0, 4'hF, 0);
        for (int i = 0; i < 8; i++) rd("R2", 4'(i), 4'(7 - i));
        // R3 MEM writes
        for (int i = 0; i < 8; i++) begin
            drive(4'hF, 0, 4'(i), 32'h2000_0000 + i); step;
        end
        drive(4'hF, 0, 4'hF, 0);
        for (int i = 0; i < 8; i++) rd("R3", 4'(i), 4'(i));
        // R4 distinct targets
        drive(4'd1, 32'hAAAA_0001, 4'd6, 32'hBBBB_0006); step;
        drive(4'hF, 0, 4'hF, 0);
        rd("R4", 4'd1, 4'd6);
        chk("R4", rd_x_data, 32'hAAAA_0001); chk("R4", rd_y_data, 32'hBBBB_0006);
        // R5 same target: MEM wins
        drive(4'd3, 32'hEEEE_EEEE, 4'd3, 32'h3333_3333); step;
        drive(4'hF, 0, 4'hF, 0);
        rd_x_id = 3; #0.5; chk("R5", rd_x_data, 32'h3333_3333);
        // R6 null and unused write IDs
        for (int k = 8; k < 16; k++) begin
            drive(4'(k), 32'hDEAD_0000 + k, 4'(k), 32'hBEEF_0000 + k); step;
            for (int i = 0; i < 8; i++) rd("R6", 4'(i), 4'(i));
        end
        drive(4'hF, 0, 4'hF, 0);
        // R7 reads of unused IDs
        for (int k = 8; k < 16; k++) begin
            rd_x_id = 4'(k); rd_y_id = 4'(k); #0.5;
            chk("R7", rd_x_data, 0); chk("R7", rd_y_data, 0);
        end
        // R8 no bypass
        drive(4'd5, 32'h5555_AAAA, 4'hF, 0);
        rd_x_id = 5; #0.5; chk("R8", rd_x_data, 32'h2000_0005);
        step; drive(4'hF, 0, 4'hF, 0);
        rd_x_id = 5; #0.5; chk("R8", rd_x_data, 32'h5555_AAAA);
        // R9 random four-port traffic
        for (int n = 0; n < 400; n++) begin
            drive(4'($urandom), $urandom, 4'($urandom), $urandom);
            rd("R9", 4'($urandom), 4'($urandom));
            step;
        end
        drive(4'hF, 0, 4'hF, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule